// File: doc/BRIEF.md
# Iterative Integer and Fractional Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. It works one quotient bit per clock, using a non-restoring recurrence on operand magnitudes. The signs are applied afterwards. Every operation takes the same number of active clocks, whatever the operands.

A caller pulses `start` with the operands and three mode selects: dividend width, integer or fractional format, and signed or unsigned. It then waits for the single-cycle `done` pulse. The `hold` input suspends the operation at any cycle. While it is high, every internal register keeps its value, so a caller that must stop a divide part way can resume it later with no loss.

In fractional mode the 16-bit dividend is scaled by 2^15 before the divide. The quotient is then a 1.15 fixed-point value. A divide by zero, or a quotient that does not fit the 16-bit result format, raises `err`, and the quotient is then undefined.

Top module: `seqdiv`

## Requirements
- R1: In unsigned integer mode (`frac`=0, `sgn`=0) the quotient is floor(N/D) and the remainder is N mod D. N is `dividend[31:0]` when `wide`=1 and `dividend[15:0]` when `wide`=0.
- R2: In signed integer mode (`sgn`=1) the operands are two's complement. The quotient is truncated toward zero, its sign is the XOR of the operand signs, and a non-zero remainder takes the sign of the dividend.
- R3: `start` is accepted only when the block is idle and `hold` is low. `done` is a one-cycle pulse, registered on the 19th non-held rising edge, counting the accepting edge as the first. A `start` while an operation is in progress is ignored.
- R4: In fractional mode (`frac`=1) the dividend is `dividend[15:0]` and `wide` has no effect. The result is trunc(A*2^15/D) with remainder (A*2^15) rem D. Signedness and signs follow R1 and R2.
- R5: Each clock edge with `hold` high during an operation adds exactly one cycle to the latency and leaves the result unchanged.
- R6: A zero divisor sets `err` with `done`.
- R7: `err` is set when the true quotient does not fit: above 65535 when unsigned, or outside -32768..32767 when signed. This includes a fractional signed divide with |A| >= |D|, except that -1.0 (0x8000) is valid.
- R8: After reset, `done`, `err`, `quotient` and `remainder` are all 0.
- R9: `quotient`, `remainder` and `err` change only on the edge that raises `done`, and hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the present operands |
| hold | input | 1 | Freeze all progress while high |
| wide | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| frac | input | 1 | 1: fractional 1.15 format, 0: integer |
| sgn | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| err | output | 1 | Divide by zero or quotient overflow |

## Verification
A wrong sequencer count shows at the ports as a `done` pulse one or more cycles early or late. Because the latency is fixed, that is caught on the very first operation. A fault in the partial-remainder recurrence or the final fix-up shows as a wrong quotient or remainder at the next `done`. A register that drifts while `hold` is high shows as a shifted `done` or a corrupted result, so operations are repeated with holds inserted at random cycles. Sign and overflow faults show only for particular operand signs and magnitudes, so the cases cover each sign pairing, the -32768 limits and the fractional |A| = |D| boundary.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

    localparam int DIV_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ITER,
        PH_FIX,
        PH_OUT
    } phase_e;

    typedef struct packed {
        logic qneg;
        logic rneg;
        logic sgn;
        logic zdiv;
        logic hi_ovf;
    } div_flags_t;

endpackage

// File: rtl/seqdiv_seq.sv
module seqdiv_seq
    import seqdiv_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   hold,
    output logic   busy,
    output logic   load,
    output logic   adv,
    output logic   finish,
    output phase_e phase
);
    localparam int LAST = W + 2;
    localparam int CW   = $clog2(LAST + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        load = start && !busy && !hold;
        adv  = busy && !hold;
        if (!busy)
            phase = PH_IDLE;
        else if (cnt <= CW'(W))
            phase = PH_ITER;
        else if (cnt == CW'(W + 1))
            phase = PH_FIX;
        else
            phase = PH_OUT;
        finish = adv && (phase == PH_OUT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
        end else if (adv) begin
            if (cnt == CW'(LAST)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: an active operation always has its step count in range
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt >= CW'(1)) && (cnt <= CW'(LAST)));

    // R5: a held cycle neither advances nor ends the operation
    p_hold_cnt_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && hold) |=> (busy && $stable(cnt)));

endmodule

// File: rtl/seqdiv_core.sv
module seqdiv_core
    import seqdiv_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           adv,
    input  phase_e         phase,
    input  logic           wide,
    input  logic           frac,
    input  logic           sgn,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   q_raw,
    output logic [W-1:0]   r_raw,
    output logic [W-1:0]   dmag_o,
    output div_flags_t     flags
);
    localparam int PW = W + 2;

    logic [PW-1:0]  pr;
    logic [W-1:0]   nlo;
    logic [W-1:0]   qacc;
    logic [W-1:0]   dmag;

    logic [W-1:0]   a_lo, a_mag, d_mag;
    logic           a16_neg, a_neg, d_neg;
    logic [2*W-1:0] num;
    logic [PW-1:0]  sh, dext, nxt;

    // operand magnitudes and alignment
    always_comb begin
        a_lo    = dividend[W-1:0];
        a16_neg = sgn & a_lo[W-1];
        a_mag   = a16_neg ? -a_lo : a_lo;
        if (frac) begin
            a_neg = a16_neg;
            num   = {{W{1'b0}}, a_mag} << (W - 1);
        end else if (wide) begin
            a_neg = sgn & dividend[2*W-1];
            num   = a_neg ? -dividend : dividend;
        end else begin
            a_neg = a16_neg;
            num   = {{W{1'b0}}, a_mag};
        end
        d_neg = sgn & divisor[W-1];
        d_mag = d_neg ? -divisor : divisor;
    end

    // one non-restoring step
    always_comb begin
        sh   = {pr[W:0], nlo[W-1]};
        dext = {2'b00, dmag};
        nxt  = pr[PW-1] ? (sh + dext) : (sh - dext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr    <= '0;
            nlo   <= '0;
            qacc  <= '0;
            dmag  <= '0;
            flags <= '0;
        end else if (load) begin
            pr           <= {2'b00, num[2*W-1:W]};
            nlo          <= num[W-1:0];
            qacc         <= '0;
            dmag         <= d_mag;
            flags.qneg   <= a_neg ^ d_neg;
            flags.rneg   <= a_neg;
            flags.sgn    <= sgn;
            flags.zdiv   <= (d_mag == '0);
            flags.hi_ovf <= (num[2*W-1:W] >= d_mag);
        end else if (adv) begin
            case (phase)
                PH_ITER: begin
                    pr   <= nxt;
                    nlo  <= nlo << 1;
                    qacc <= {qacc[W-2:0], ~nxt[PW-1]};
                end
                PH_FIX: begin
                    if (pr[PW-1])
                        pr <= pr + dext;
                end
                default: ;
            endcase
        end
    end

    assign q_raw  = qacc;
    assign r_raw  = pr[W-1:0];
    assign dmag_o = dmag;

    // R1: after fix-up the partial remainder lies in [0, divisor)
    p_rem_range_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OUT && !flags.zdiv && !flags.hi_ovf)
            |-> (!pr[PW-1] && (pr < dext)));

endmodule

// File: rtl/seqdiv_fmt.sv
module seqdiv_fmt
    import seqdiv_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic [W-1:0] q_raw,
    input  logic [W-1:0] r_raw,
    input  div_flags_t   flags,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         err
);
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic sovf;

    always_comb begin
        sovf = flags.sgn & (flags.qneg ? (q_raw > NEG_LIMIT) : q_raw[W-1]);
        err  = flags.zdiv | flags.hi_ovf | sovf;
        quo  = flags.qneg ? -q_raw : q_raw;
        rem  = flags.rneg ? -r_raw : r_raw;
    end

endmodule

// File: rtl/seqdiv.sv
module seqdiv
    import seqdiv_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           hold,
    input  logic           wide,
    input  logic           frac,
    input  logic           sgn,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           done,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           err
);
    logic       busy, load, adv, finish;
    phase_e     phase;
    logic [W-1:0] q_raw, r_raw, dmag, f_quo, f_rem;
    logic       f_err;
    div_flags_t flags;

    seqdiv_seq #(.W(W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .hold(hold),
        .busy(busy), .load(load), .adv(adv), .finish(finish), .phase(phase)
    );

    seqdiv_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .phase(phase),
        .wide(wide), .frac(frac), .sgn(sgn),
        .dividend(dividend), .divisor(divisor),
        .q_raw(q_raw), .r_raw(r_raw), .dmag_o(dmag), .flags(flags)
    );

    seqdiv_fmt #(.W(W)) u_fmt (
        .q_raw(q_raw), .r_raw(r_raw), .flags(flags),
        .quo(f_quo), .rem(f_rem), .err(f_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            err       <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                quotient  <= f_quo;
                remainder <= f_rem;
                err       <= f_err;
            end
        end
    end

    // R3: result strobe lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: a held cycle changes no partial result and produces no strobe
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && hold) |=> ($stable(q_raw) && $stable(r_raw) && !done));

    // R6: divide by zero is always flagged
    p_zero_div_r6: assert property (@(posedge clk) disable iff (rst)
        (done && dmag == '0) |-> err);

    // R2: signed non-zero remainder carries the dividend sign
    p_rem_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !err && flags.sgn && remainder != '0)
            |-> (remainder[W-1] == flags.rneg));

    // R9: results change only together with the strobe
    p_out_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !($stable(quotient) && $stable(remainder) && $stable(err)) |-> done);

endmodule

// File: tb/seqdiv_bench.sv
module seqdiv_bench;
    logic        clk = 1'b0;
    logic        rst, start, hold, wide, frac, sgn;
    logic [31:0] dividend;
    logic [15:0] divisor;
    logic        done, err;
    logic [15:0] quotient, remainder;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    seqdiv u_seqdiv (
        .clk(clk), .rst(rst), .start(start), .hold(hold),
        .wide(wide), .frac(frac), .sgn(sgn),
        .dividend(dividend), .divisor(divisor),
        .done(done), .quotient(quotient), .remainder(remainder), .err(err)
    );

    // vector: {wide, frac, sgn, dividend[31:0], divisor[15:0]}
    localparam int NV = 18;
    localparam logic [50:0] VEC [NV] = '{
        {3'b000, 32'h0000_03E8, 16'h0007},   // 1000/7
        {3'b100, 32'h0012_3456, 16'h0100},   // 32/16 unsigned
        {3'b001, 32'h0000_FF9C, 16'h0007},   // -100/7
        {3'b001, 32'h0000_0064, 16'hFFF9},   // 100/-7
        {3'b101, 32'hFFF0_BDC0, 16'hFED4},   // -1000000/-300
        {3'b011, 32'h0000_2000, 16'h4000},   // 0.25/0.5
        {3'b011, 32'h0000_E000, 16'h4000},   // -0.25/0.5
        {3'b010, 32'h0000_1000, 16'h3000},   // unsigned fractional
        {3'b000, 32'h0000_1234, 16'h0000},   // zero divisor
        {3'b100, 32'h0001_0000, 16'h0001},   // unsigned overflow
        {3'b001, 32'h0000_8000, 16'hFFFF},   // -32768/-1 overflow
        {3'b001, 32'h0000_8000, 16'h0001},   // -32768/1 fits
        {3'b011, 32'h0000_4000, 16'h4000},   // frac +1.0 overflow
        {3'b011, 32'h0000_C000, 16'h4000},   // frac -1.0 fits
        {3'b111, 32'hABCD_2000, 16'hC000},   // wide ignored in frac
        {3'b000, 32'h0000_FFFF, 16'hFFFF},   // max/max
        {3'b100, 32'hFFFE_0001, 16'hFFFF},   // largest 32/16 quotient
        {3'b101, 32'h8000_0000, 16'h0001}    // signed 32-bit overflow
    };

    function automatic void model(input logic [50:0] v, output logic [15:0] eq,
                                  output logic [15:0] er, output logic ee);
        longint a, b, q, r;
        logic [31:0] dd;
        logic [15:0] dv;
        dd = v[47:16];
        dv = v[15:0];
        if (v[49]) begin
            a = v[48] ? longint'($signed(dd[15:0])) : longint'(dd[15:0]);
            a = a * 32768;
        end else if (v[50]) begin
            a = v[48] ? longint'($signed(dd)) : longint'(dd);
        end else begin
            a = v[48] ? longint'($signed(dd[15:0])) : longint'(dd[15:0]);
        end
        b = v[48] ? longint'($signed(dv)) : longint'(dv);
        if (b == 0) begin
            ee = 1'b1; eq = '0; er = '0;
            return;
        end
        q  = a / b;
        r  = a % b;
        ee = v[48] ? (q > 32767 || q < -32768) : (q > 65535);
        eq = q[15:0];
        er = r[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [50:0] v, input logic ee);
        if (ee && v[15:0] == 16'h0) return "R6";
        if (ee) return "R7";
        if (v[49]) return "R4";
        if (v[48]) return "R2";
        return "R1";
    endfunction

    task automatic run(input logic [50:0] v, input bit rnd_hold);
        logic [15:0] eq, er;
        logic        ee, hv;
        int          active;
        bit          seen;
        string       tg;
        model(v, eq, er, ee);
        tg = tag_of(v, ee);
        @(negedge clk);
        {wide, frac, sgn, dividend, divisor} = v;
        start = 1'b1;
        hold  = 1'b0;
        @(negedge clk);
        start  = 1'b0;
        active = 1;
        seen   = 0;
        for (int k = 0; k < 200 && !seen; k++) begin
            hold = rnd_hold ? (($urandom % 3) == 0) : 1'b0;
            hv   = hold;
            @(posedge clk);
            if (!hv) active++;
            @(negedge clk);
            if (done) seen = 1;
        end
        hold = 1'b0;
        chk(seen && active == 19, rnd_hold ? "R5" : "R3", "latency",
            32'(active), 32'd19);
        chk(err == ee, tg, "err", {31'b0, err}, {31'b0, ee});
        if (!ee) begin
            chk(quotient == eq, tg, "quotient", {16'b0, quotient}, {16'b0, eq});
            chk(remainder == er, tg, "remainder", {16'b0, remainder}, {16'b0, er});
        end
        @(negedge clk);
        chk(!done, "R3", "done pulse width", {31'b0, done}, 32'd0);
        chk(quotient == (ee ? quotient : eq) && remainder == (ee ? remainder : er),
            "R9", "result held", {quotient, remainder}, {eq, er});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] eq, er;
        logic        ee;
        int          n;
        rst = 1'b1; start = 1'b0; hold = 1'b0;
        wide = 1'b0; frac = 1'b0; sgn = 1'b0;
        dividend = '0; divisor = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk(!done && !err && quotient == 16'h0 && remainder == 16'h0, "R8",
            "reset outputs", {done, err, 14'b0, quotient}, 32'd0);

        for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);
        for (int i = 0; i < NV; i++) run(VEC[i], 1'b1);

        // R3: start while busy is ignored; result is from the first operands
        model(VEC[0], eq, er, ee);
        @(negedge clk);
        {wide, frac, sgn, dividend, divisor} = VEC[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        {wide, frac, sgn, dividend, divisor} = VEC[3];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 7;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(done && n == 19, "R3", "latency with ignored start", 32'(n), 32'd19);
        chk(quotient == eq && remainder == er, "R3", "ignored start result",
            {quotient, remainder}, {eq, er});
        @(negedge clk);
        chk(!done, "R3", "no second strobe", {31'b0, done}, 32'd0);

        // R5: a long hold burst in the middle of an operation
        model(VEC[4], eq, er, ee);
        {wide, frac, sgn, dividend, divisor} = VEC[4];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        hold = 1'b1;
        repeat (12) @(negedge clk);
        chk(!done, "R5", "no strobe during hold", {31'b0, done}, 32'd0);
        hold = 1'b0;
        n = 9;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(done && n == 19, "R5", "active edges with hold burst", 32'(n), 32'd19);
        chk(quotient == eq && remainder == er, "R5", "result after hold burst",
            {quotient, remainder}, {eq, er});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule